// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division over many cycles and keeps its results in a private pair of registers, HI and LO. A two-operand multiply leaves the full 64-bit product split across the pair, with the upper half in HI. A divide leaves the quotient in LO and the remainder in HI. Separate commands copy an operand into either register or return either register's value. A further multiply form returns only the low half of a signed product on the result port and does not change the pair.

A command is issued with a one-cycle `start` strobe that carries an operation code and two operands. Arithmetic commands raise `busy` for a fixed number of cycles. Register reads answer with a one-cycle `resValid` pulse on `result`. A read that arrives while an arithmetic command is running is held and answered with the fresh value on the cycle the command completes. Division by zero and the signed overflow case give fixed, documented results and never trap.

Top module: `mdu_hilo`

## Requirements
- R1: Op code 0 (signed multiply) writes the two's-complement 64-bit product of `opA` and `opB`, upper half to HI and lower half to LO.
- R2: Op code 1 (unsigned multiply) writes the unsigned 64-bit product of `opA` and `opB`, upper half to HI and lower half to LO.
- R3: Op code 2 (signed divide) writes the quotient `opA/opB`, truncated toward zero, to LO and the remainder, which carries the sign of `opA`, to HI.
- R4: Op code 3 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R5: When either divide has `opB` equal to zero, LO becomes all ones and HI becomes `opA` unchanged.
- R6: Signed divide of 0x80000000 by 0xFFFFFFFF leaves LO = 0x80000000 and HI = 0, with no other effect.
- R7: When idle, op code 4 (read HI) or 5 (read LO) presents that register on `result` with `resValid` high for exactly the next cycle; `busy` stays low and `resValid` is low in any cycle that follows an edge with neither a start nor a completion.
- R8: When idle, op code 6 (write HI) or 7 (write LO) copies `opA` into that register at the accepting edge without raising `busy`.
- R9: Op code 8 (low-half multiply) returns the low 32 bits of the signed product on `result` with a `resValid` pulse on the cycle `busy` falls, and leaves HI and LO unchanged.
- R10: After the edge that accepts an arithmetic command (op codes 0 to 3 and 8), `busy` is high for exactly W+1 cycles (33 at W = 32).
- R11: A read (op code 4 or 5) issued while a command other than op code 8 is running gets no answer before completion; it is answered with `resValid` on the cycle `busy` falls, carrying the newly written register value.
- R12: A start while busy that is not a read, any start during an op code 8 command, and any idle start with an op code above 8 change neither HI nor LO and produce no `resValid`.
- R13: After reset `busy`, `resValid` and `result` are low and HI and LO read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command strobe |
| op | input | 4 | Operation code, sampled with `start` |
| opA | input | 32 | First operand (multiplier, dividend, or value to write) |
| opB | input | 32 | Second operand (multiplicand or divisor) |
| busy | output | 1 | High while an arithmetic command is in progress |
| resValid | output | 1 | One-cycle pulse marking a new value on `result` |
| result | output | 32 | Register read-back or low-half product |

## Verification
The two functions that can fall in one cycle are the completion of an arithmetic command and a register read: a read issued in the middle of a multiply must be held and then served from the value being written on the completion edge, not the stale one. The bench provokes this by strobing a read of LO several cycles into a signed multiply. It then requires `resValid` to stay low while `busy` is high and to rise together with the fall of `busy`, carrying the new product half. A write strobed during a divide is the companion case; the bench judges it by reading HI back afterwards and expecting the remainder.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_MULS  = 4'd0,
    OP_MULU  = 4'd1,
    OP_DIVS  = 4'd2,
    OP_DIVU  = 4'd3,
    OP_RDHI  = 4'd4,
    OP_RDLO  = 4'd5,
    OP_WRHI  = 4'd6,
    OP_WRLO  = 4'd7,
    OP_MULLO = 4'd8
  } mdu_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMul;   // capture operands for a multiply
    logic loadDiv;   // capture operands for a divide
    logic signedOp;  // operands are two's complement
    logic step;      // one shift-add or shift-subtract iteration
    logic isDiv;     // running command is a divide
    logic finish;    // sign fix-up and write-back
    logic mulLo;     // running command is the low-half multiply
    logic wrHi;
    logic wrLo;
    logic rdHi;
    logic rdLo;
  } mdu_ctl_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] op,
  output mdu_ctl_t   ctl,
  output logic       busy
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e           state;
  logic [CW-1:0] cnt;
  logic          divQ, mulLoQ, pendQ, pendHiQ;

  logic isRd, isMulOp, isDivOp, accept, lastStep, svcRd, svcHi;

  always_comb begin
    isRd     = start && (op == OP_RDHI || op == OP_RDLO);
    isMulOp  = (op == OP_MULS) || (op == OP_MULU) || (op == OP_MULLO);
    isDivOp  = (op == OP_DIVS) || (op == OP_DIVU);
    accept   = (state == ST_IDLE) && start;
    lastStep = (cnt == CW'(W - 1));
    // a held read, or one arriving in the completion cycle, is served now
    svcRd    = (state == ST_FIN) && !mulLoQ && (pendQ || isRd);
    svcHi    = isRd ? (op == OP_RDHI) : pendHiQ;

    ctl          = '0;
    ctl.loadMul  = accept && isMulOp;
    ctl.loadDiv  = accept && isDivOp;
    ctl.signedOp = (op == OP_MULS) || (op == OP_DIVS) || (op == OP_MULLO);
    ctl.step     = (state == ST_RUN);
    ctl.isDiv    = divQ;
    ctl.finish   = (state == ST_FIN);
    ctl.mulLo    = mulLoQ;
    ctl.wrHi     = accept && (op == OP_WRHI);
    ctl.wrLo     = accept && (op == OP_WRLO);
    ctl.rdHi     = (accept && op == OP_RDHI) || (svcRd && svcHi);
    ctl.rdLo     = (accept && op == OP_RDLO) || (svcRd && !svcHi);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      divQ    <= 1'b0;
      mulLoQ  <= 1'b0;
      pendQ   <= 1'b0;
      pendHiQ <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          pendQ <= 1'b0;
          if (ctl.loadMul || ctl.loadDiv) begin
            state  <= ST_RUN;
            cnt    <= '0;
            divQ   <= ctl.loadDiv;
            mulLoQ <= (op == OP_MULLO);
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (lastStep) state <= ST_FIN;
          if (isRd && !mulLoQ) begin
            pendQ   <= 1'b1;
            pendHiQ <= (op == OP_RDHI);
          end
        end
        default: begin
          state <= ST_IDLE;
          pendQ <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdu_ctl_t     ctl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiVal,
  output logic [W-1:0] loVal,
  output logic [W-1:0] result,
  output logic         resValid
);

  logic [W-1:0] hiQ, loQ, pHi, pLo, dvQ, resQ;
  logic         negProdQ, negQuoQ, negRemQ, zeroQ, validQ;

  logic           sgnA, sgnB;
  logic [W-1:0]   absA, absB;
  logic [W:0]     mulSum;
  logic [W:0]     remSh;
  logic           fits;
  logic [W-1:0]   remSub;
  logic [2*W-1:0] prodMag, prodFix;
  logic [W-1:0]   quoFix, remFix;
  logic           finArith;
  logic [W-1:0]   hiNext, loNext;

  always_comb begin
    sgnA    = ctl.signedOp && opA[W-1];
    sgnB    = ctl.signedOp && opB[W-1];
    absA    = sgnA ? (~opA + 1'b1) : opA;
    absB    = sgnB ? (~opB + 1'b1) : opB;
    // multiply iteration: conditional add into the upper half, then shift right
    mulSum  = {1'b0, pHi} + (pLo[0] ? {1'b0, dvQ} : '0);
    // divide iteration: shift left, trial subtract, keep if it fits
    remSh   = {pHi, pLo[W-1]};
    fits    = (remSh >= {1'b0, dvQ});
    remSub  = remSh[W-1:0] - dvQ;
    prodMag = {pHi, pLo};
    prodFix = negProdQ ? (~prodMag + 1'b1) : prodMag;
    quoFix  = zeroQ ? '1 : (negQuoQ ? (~pLo + 1'b1) : pLo);
    remFix  = negRemQ ? (~pHi + 1'b1) : pHi;

    finArith = ctl.finish && !ctl.mulLo;
    hiNext   = hiQ;
    loNext   = loQ;
    if (ctl.wrHi) hiNext = opA;
    if (ctl.wrLo) loNext = opA;
    if (finArith) begin
      hiNext = ctl.isDiv ? remFix : prodFix[2*W-1:W];
      loNext = ctl.isDiv ? quoFix : prodFix[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ      <= '0;
      loQ      <= '0;
      pHi      <= '0;
      pLo      <= '0;
      dvQ      <= '0;
      resQ     <= '0;
      negProdQ <= 1'b0;
      negQuoQ  <= 1'b0;
      negRemQ  <= 1'b0;
      zeroQ    <= 1'b0;
      validQ   <= 1'b0;
    end else begin
      if (ctl.loadMul || ctl.loadDiv) begin
        pHi      <= '0;
        pLo      <= absA;
        dvQ      <= absB;
        negProdQ <= sgnA ^ sgnB;
        negQuoQ  <= (sgnA ^ sgnB) && (opB != '0);
        negRemQ  <= sgnA;
        zeroQ    <= (opB == '0);
      end else if (ctl.step) begin
        if (ctl.isDiv) begin
          pHi <= fits ? remSub : remSh[W-1:0];
          pLo <= {pLo[W-2:0], fits};
        end else begin
          pHi <= mulSum[W:1];
          pLo <= {mulSum[0], pLo[W-1:1]};
        end
      end
      hiQ    <= hiNext;
      loQ    <= loNext;
      validQ <= ctl.rdHi || ctl.rdLo || (ctl.finish && ctl.mulLo);
      if (ctl.rdHi)                     resQ <= hiNext;
      else if (ctl.rdLo)                resQ <= loNext;
      else if (ctl.finish && ctl.mulLo) resQ <= prodFix[W-1:0];
    end
  end

  assign hiVal    = hiQ;
  assign loVal    = loQ;
  assign result   = resQ;
  assign resValid = validQ;

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         resValid,
  output logic [W-1:0] result
);

  mdu_ctl_t     ctl;
  logic [W-1:0] hiVal, loVal;

  mdu_ctrl #(.W(W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .op    (op),
    .ctl   (ctl),
    .busy  (busy)
  );

  mdu_dp #(.W(W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .hiVal    (hiVal),
    .loVal    (loVal),
    .result   (result),
    .resValid (resValid)
  );

endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [3:0]   op,
  input logic [W-1:0] opA,
  input logic         busy,
  input logic         resValid,
  input logic [W-1:0] result,
  input logic [W-1:0] hiVal,
  input logic [W-1:0] loVal
);

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (op <= 4'd3 || op == 4'd8)) |=> busy); // R10

  AST_IDLE_READ_HI: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && op == 4'd4) |=> (resValid && !busy && result == $past(hiVal))); // R7

  AST_IDLE_READ_LO: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && op == 4'd5) |=> (resValid && !busy && result == $past(loVal))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> (!resValid && !busy)); // R7

  AST_WRITE_HI: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && op == 4'd6) |=> (!busy && hiVal == $past(opA))); // R8

  AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && op == 4'd7) |=> (!busy && loVal == $past(opA))); // R8

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (($stable(hiVal) && $stable(loVal)) || $fell(busy))); // R12

  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && op > 4'd8) |=> (!busy && !resValid && $stable(hiVal) && $stable(loVal))); // R12

endmodule

bind mdu_hilo mdu_hilo_chk #(.W(W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .op       (op),
  .opA      (opA),
  .busy     (busy),
  .resValid (resValid),
  .result   (result),
  .hiVal    (hiVal),
  .loVal    (loVal)
);

// File: tb/sim_mdu_hilo.sv
module sim_mdu_hilo;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy, resValid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  mdu_hilo #(.W(32)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .busy(busy), .resValid(resValid), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    start = 1'b1; op = o; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runArith(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                          output int cyc, output logic v, output logic [31:0] res);
    issue(o, a, b);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    v = resValid;
    res = result;
  endtask

  task automatic readReg(input logic [3:0] o, output logic [31:0] val, output logic v);
    issue(o, 32'h0, 32'h0);
    v = resValid;
    val = result;
  endtask

  task automatic expectPair(input string tag, input logic [31:0] eHi, input logic [31:0] eLo);
    logic [31:0] val;
    logic v;
    readReg(4'd4, val, v);
    chk(v && val == eHi, {tag, " HI"}, val, eHi);
    readReg(4'd5, val, v);
    chk(v && val == eLo, {tag, " LO"}, val, eLo);
  endtask

  task automatic testMul(input bit sgn, input logic [31:0] a, input logic [31:0] b, input string tag);
    int cyc;
    logic v;
    logic [31:0] res;
    logic [63:0] p;
    if (sgn) p = 64'($signed(a)) * 64'($signed(b));
    else     p = {32'h0, a} * {32'h0, b};
    runArith(sgn ? 4'd0 : 4'd1, a, b, cyc, v, res);
    chk(cyc == 33, "R10 multiply busy length", 32'(cyc), 32'd33);
    expectPair(tag, p[63:32], p[31:0]);
  endtask

  task automatic testDiv(input bit sgn, input logic [31:0] a, input logic [31:0] b, input string tag);
    int cyc;
    logic v;
    logic [31:0] res, q, r;
    longint sa, sb;
    if (b == 32'h0) begin
      q = 32'hFFFF_FFFF;
      r = a;
    end else if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q = 32'(sa / sb);
      r = 32'(sa % sb);
    end else begin
      q = a / b;
      r = a % b;
    end
    runArith(sgn ? 4'd2 : 4'd3, a, b, cyc, v, res);
    chk(cyc == 33, "R10 divide busy length", 32'(cyc), 32'd33);
    expectPair(tag, r, q);
  endtask

  task automatic testReset();
    logic [31:0] val;
    logic v;
    chk(busy == 1'b0, "R13 busy after reset", 32'(busy), 32'd0);
    chk(resValid == 1'b0, "R13 resValid after reset", 32'(resValid), 32'd0);
    chk(result == 32'h0, "R13 result after reset", result, 32'h0);
    readReg(4'd4, val, v);
    chk(v && val == 32'h0, "R13 HI after reset", val, 32'h0);
    readReg(4'd5, val, v);
    chk(v && val == 32'h0, "R13 LO after reset", val, 32'h0);
  endtask

  task automatic testWriteRead();
    logic [31:0] val;
    logic v;
    issue(4'd6, 32'hA5A5_1234, 32'h0);
    chk(busy == 1'b0, "R8 write HI stays idle", 32'(busy), 32'd0);
    chk(resValid == 1'b0, "R8 write gives no resValid", 32'(resValid), 32'd0);
    issue(4'd7, 32'h0F0F_8765, 32'h0);
    readReg(4'd4, val, v);
    chk(v && val == 32'hA5A5_1234, "R8 HI written", val, 32'hA5A5_1234);
    chk(busy == 1'b0, "R7 read stays idle", 32'(busy), 32'd0);
    @(negedge clk);
    chk(resValid == 1'b0, "R7 resValid lasts one cycle", 32'(resValid), 32'd0);
    readReg(4'd5, val, v);
    chk(v && val == 32'h0F0F_8765, "R7 R8 LO written", val, 32'h0F0F_8765);
  endtask

  task automatic testMulLo();
    int cyc;
    logic v;
    logic [31:0] res;
    logic [63:0] p;
    issue(4'd6, 32'h1111_2222, 32'h0);
    issue(4'd7, 32'h3333_4444, 32'h0);
    runArith(4'd8, 32'hFFFF_FFFC, 32'd5, cyc, v, res);
    chk(cyc == 33, "R10 low-half multiply busy length", 32'(cyc), 32'd33);
    chk(v && res == 32'hFFFF_FFEC, "R9 low-half product", res, 32'hFFFF_FFEC);
    expectPair("R9 pair unchanged", 32'h1111_2222, 32'h3333_4444);
    p = 64'($signed(32'h8000_0001)) * 64'($signed(32'h7FFF_FFFF));
    runArith(4'd8, 32'h8000_0001, 32'h7FFF_FFFF, cyc, v, res);
    chk(v && res == p[31:0], "R9 low-half product large", res, p[31:0]);
  endtask

  task automatic testPendingRead();
    logic [63:0] p;
    bit early;
    p = 64'($signed(32'hDEAD_BEEF)) * 64'($signed(32'h0123_4567));
    issue(4'd0, 32'hDEAD_BEEF, 32'h0123_4567);
    repeat (5) @(negedge clk);
    issue(4'd5, 32'h0, 32'h0);
    early = 1'b0;
    while (busy) begin
      if (resValid) early = 1'b1;
      @(negedge clk);
    end
    chk(!early, "R11 no answer before completion", 32'(early), 32'd0);
    chk(resValid == 1'b1, "R11 answer when busy falls", 32'(resValid), 32'd1);
    chk(result == p[31:0], "R11 answer carries new LO", result, p[31:0]);
  endtask

  task automatic testIgnored();
    logic [31:0] val;
    logic v;
    bit seen;
    // write during a divide has no effect: HI ends as the remainder
    issue(4'd3, 32'd100, 32'd7);
    repeat (3) @(negedge clk);
    issue(4'd6, 32'hCAFE_F00D, 32'h0);
    while (busy) @(negedge clk);
    expectPair("R12 write while busy ignored", 32'd2, 32'd14);
    // unknown op code while idle
    issue(4'd12, 32'h7777_7777, 32'h0);
    chk(resValid == 1'b0 && busy == 1'b0, "R12 unknown op quiet", {30'h0, busy, resValid}, 32'h0);
    readReg(4'd4, val, v);
    chk(v && val == 32'd2, "R12 unknown op leaves HI", val, 32'd2);
    // read during a low-half multiply is dropped
    issue(4'd8, 32'd6, 32'd7);
    repeat (2) @(negedge clk);
    issue(4'd4, 32'h0, 32'h0);
    seen = 1'b0;
    while (busy) begin
      if (resValid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen && result == 32'd42, "R12 read during low-half multiply dropped", result, 32'd42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteRead();
    testMul(1'b1, 32'hFFFF_FFFD, 32'd7, "R1 small negative");
    testMul(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R1 max positive");
    testMul(1'b1, 32'h8000_0000, 32'h8000_0000, "R1 min negative");
    testMul(1'b1, 32'h8000_0000, 32'h0000_0001, "R1 min times one");
    testMul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 all ones");
    testMul(1'b0, 32'h0, 32'h1234_5678, "R2 zero");
    testDiv(1'b1, 32'hFFFF_FFF9, 32'd2, "R3 negative dividend");
    testDiv(1'b1, 32'd7, 32'hFFFF_FFFE, "R3 negative divisor");
    testDiv(1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R3 both negative");
    testDiv(1'b0, 32'hFFFF_FFFF, 32'd3, "R4 large dividend");
    testDiv(1'b0, 32'd5, 32'hFFFF_FFFF, "R4 divisor larger");
    testDiv(1'b1, 32'hFFFF_FFFB, 32'h0, "R5 signed by zero");
    testDiv(1'b0, 32'd123, 32'h0, "R5 unsigned by zero");
    testDiv(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R6 overflow case");
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom() >> (i * 5);
      testMul(1'b1, a, b, "R1 random");
      testMul(1'b0, a, b, "R2 random");
      if (b != 32'h0) begin
        testDiv(1'b1, a, b, "R3 random");
        testDiv(1'b0, a, b, "R4 random");
      end
    end
    testMulLo();
    testPendingRead();
    testIgnored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule